// File: doc/BRIEF.md
# Smart Card Reset Release Sequencer

This block drives the active-low reset line of a contact smart card. It holds the card in reset until two conditions are met: the card supply is reported good, and firmware has not asked for the card to be held in reset. Once both hold, the block waits a programmable number of elementary time units (ETU). Only then does it drive the reset line high. A delay of zero releases the line on the first clock where both conditions are met.

Firmware can set the hold bit before it switches on card power. The card then stays in reset for as long as the bit stays set, and firmware chooses the moment of release. Setting the hold bit at any time, or losing the supply, pulls reset low again. On the clock edge where reset goes high, the block emits a one-cycle pulse that can start the timer for the first character of the answer-to-reset.

Top module: `card_rst_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `card_rst_n` and `release_pulse` are 0.
- R2: When `supply_ok` is sampled low, `card_rst_n` is 0 after that edge, and any countdown is dropped. When the supply returns, a full new delay starts.
- R3: When `hold_rst` is sampled high, `card_rst_n` is 0 after that edge.
- R4: With `delay_etu` equal to 0, the release edge is the first edge that samples `supply_ok` high and `hold_rst` low. That edge drives `card_rst_n` high.
- R5: With `delay_etu` equal to N (1..255), the edge that samples `supply_ok` high and `hold_rst` low starts a countdown. A tick on that start edge does not count. `card_rst_n` goes high on the edge that samples the N-th `etu_tick` after the start edge.
- R6: If `hold_rst` is high when the supply arrives, `card_rst_n` stays 0 for as long as the bit stays high. Clearing the bit starts the programmed delay, as in R4 and R5.
- R7: Setting `hold_rst` during a countdown aborts it. A later clear starts a full new delay.
- R8: `release_pulse` is high for exactly one cycle, namely the cycle in which `card_rst_n` has just risen. It is never high at any other time.
- R9: `delay_etu` is sampled only on the edge that starts a countdown. Changes to it during the countdown or after release have no effect.
- R10: Once released, `card_rst_n` stays high whatever `etu_tick` and `delay_etu` do, as long as `supply_ok` stays high and `hold_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| etu_tick | input | 1 | One-cycle strobe, once per ETU |
| supply_ok | input | 1 | Card supply within limits |
| hold_rst | input | 1 | Firmware request to keep the card in reset |
| delay_etu | input | 8 | Release delay in ETU, 0 means none (firmware default 0x70) |
| card_rst_n | output | 1 | Card reset pin level, 0 = card in reset |
| release_pulse | output | 1 | One-cycle strobe on reset release |

## Verification
The assertions check the following on every cycle:
- a supply loss or a hold request always pulls the pin low on the next edge;
- every rising edge of the pin coincides with the pulse and nothing else raises it;
- a release only follows a cycle with the supply good and the hold clear;
- a zero delay releases on the edge after power-good appears.

Only the bench's reference model can show the exact ETU count before release. The same holds for the start edge ignoring a tick, for a delay write during a countdown being ignored, and for an aborted countdown restarting in full.

// File: rtl/crs_pkg.sv
// Package: shared types for the card reset sequencer.
// Assumes nothing beyond a synthesizable 2-bit state encoding.
package crs_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // supply absent
        ST_HOLD  = 2'd1,   // supply good, firmware holds reset
        ST_COUNT = 2'd2,   // counting ETU toward release
        ST_ON    = 2'd3    // reset released
    } seq_state_t;
endpackage

// File: rtl/rst_etu_counter.sv
// Module: ETU down-counter for the release delay.
// Loads the delay on a load strobe and steps down once per accepted tick.
// Assumes the controller never steps it without a prior load; reports when
// the count stands at one, i.e. the next step completes the delay.
module rst_etu_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    // Holds the remaining ETU count; load wins over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (step) begin
            remain_q <= remain_q - ONE;
        end
    end

    // Flags the final ETU of the countdown.
    always_comb begin
        at_last = (remain_q == ONE);
    end
endmodule

// File: rtl/rst_seq_fsm.sv
// Module: release sequencing state machine.
// Decides each cycle whether the card is off, held, counting or released.
// Supply loss has top priority, then the firmware hold, then the sequence.
// Assumes etu_tick is a single-cycle strobe in the clk domain.
module rst_seq_fsm
    import crs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       hold_rst,
    input  logic       etu_tick,
    input  logic       delay_zero,
    input  logic       cnt_last,
    output seq_state_t state_q,
    output logic       will_be_on,
    output logic       cnt_load,
    output logic       cnt_step
);
    seq_state_t state_d;

    // Computes the next state and the counter controls.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_step = 1'b0;
        if (!supply_ok) begin
            state_d = ST_OFF;
        end else if (hold_rst) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_OFF, ST_HOLD: begin
                    if (delay_zero) begin
                        state_d = ST_ON;
                    end else begin
                        state_d  = ST_COUNT;
                        cnt_load = 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (etu_tick) begin
                        if (cnt_last) begin
                            state_d = ST_ON;
                        end else begin
                            cnt_step = 1'b1;
                        end
                    end
                end
                ST_ON: begin
                    state_d = ST_ON;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Registers the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Announces that the next state releases the card.
    always_comb begin
        will_be_on = (state_d == ST_ON);
    end
endmodule

// File: rtl/rst_pin_driver.sv
// Module: registered card reset pin and release strobe.
// Drives the pin from the sequencer's next-state decision so the pin and
// the strobe change on the same edge. Assumes drive_high is glitch-free
// at the clock edge (combinational from registered state and inputs).
module rst_pin_driver (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_high,
    output logic pin_n,
    output logic rel_pulse
);
    // Registers the pin level and marks its rising transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_n     <= 1'b0;
            rel_pulse <= 1'b0;
        end else begin
            pin_n     <= drive_high;
            rel_pulse <= drive_high & ~pin_n;
        end
    end
endmodule

// File: rtl/card_rst_seq.sv
// Module: top of the smart card reset release sequencer.
// Combines the state machine, the ETU delay counter and the pin driver.
// Assumes all inputs are synchronous to clk; delay_etu is sampled only
// when a countdown starts.
module card_rst_seq
    import crs_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             etu_tick,
    input  logic             supply_ok,
    input  logic             hold_rst,
    input  logic [DLY_W-1:0] delay_etu,
    output logic             card_rst_n,
    output logic             release_pulse
);
    localparam int CNT_W = DLY_W;

    seq_state_t state_q;
    logic       will_be_on;
    logic       cnt_load;
    logic       cnt_step;
    logic       cnt_last;
    logic       delay_zero;

    // Detects a programmed delay of zero ETU.
    always_comb begin
        delay_zero = (delay_etu == '0);
    end

    rst_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .hold_rst   (hold_rst),
        .etu_tick   (etu_tick),
        .delay_zero (delay_zero),
        .cnt_last   (cnt_last),
        .state_q    (state_q),
        .will_be_on (will_be_on),
        .cnt_load   (cnt_load),
        .cnt_step   (cnt_step)
    );

    rst_etu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (delay_etu),
        .step     (cnt_step),
        .at_last  (cnt_last)
    );

    rst_pin_driver u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_high (will_be_on),
        .pin_n      (card_rst_n),
        .rel_pulse  (release_pulse)
    );
endmodule

// File: rtl/card_rst_seq_chk.sv
// Module: property checker for card_rst_seq, bound to every instance.
// Observes ports only; assumes synchronous active-low reset.
module card_rst_seq_chk #(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             etu_tick,
    input logic             supply_ok,
    input logic             hold_rst,
    input logic [DLY_W-1:0] delay_etu,
    input logic             card_rst_n,
    input logic             release_pulse
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!card_rst_n && !release_pulse));

    assert_supply_loss_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !card_rst_n);

    assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> !card_rst_n);

    assert_zero_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(supply_ok) && supply_ok && !hold_rst && (delay_etu == '0))
        |=> card_rst_n);

    assert_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> (card_rst_n && !$past(card_rst_n)));

    assert_rise_has_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> release_pulse);

    assert_release_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> ($past(supply_ok) && !$past(hold_rst)));

    assert_stay_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rst_n && supply_ok && !hold_rst) |=> card_rst_n);
endmodule

bind card_rst_seq card_rst_seq_chk #(.DLY_W(DLY_W)) u_chk (.*);

// File: tb/card_rst_seq_test.sv
module card_rst_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       etu_tick = 1'b0;
    logic       supply_ok = 1'b0;
    logic       hold_rst = 1'b0;
    logic [7:0] delay_etu = 8'h70;
    logic       card_rst_n;
    logic       release_pulse;

    int    n_checks = 0;
    int    n_errors = 0;
    int    tick_per = 0;
    int    tick_ph  = 0;
    string cur_req  = "R1";

    // Behavioural reference: remaining < 0 means no countdown running.
    int m_remain = -1;
    bit m_rel    = 1'b0;
    bit m_pulse  = 1'b0;
    int rises    = 0;

    card_rst_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .etu_tick      (etu_tick),
        .supply_ok     (supply_ok),
        .hold_rst      (hold_rst),
        .delay_etu     (delay_etu),
        .card_rst_n    (card_rst_n),
        .release_pulse (release_pulse)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model update at every edge.
    always @(posedge clk) begin
        if (!rst_n || !supply_ok || hold_rst) begin
            m_rel    <= 1'b0;
            m_pulse  <= 1'b0;
            m_remain <= -1;
        end else if (m_rel) begin
            m_pulse <= 1'b0;
        end else if (m_remain < 0) begin
            if (delay_etu == 8'd0) begin
                m_rel   <= 1'b1;
                m_pulse <= 1'b1;
            end else begin
                m_remain <= int'(delay_etu);
                m_pulse  <= 1'b0;
            end
        end else if (etu_tick) begin
            if (m_remain == 1) begin
                m_rel    <= 1'b1;
                m_pulse  <= 1'b1;
                m_remain <= -1;
            end else begin
                m_remain <= m_remain - 1;
            end
        end
    end

    // Compare with the model shortly after each edge.
    always @(posedge clk) begin
        #2;
        check(cur_req, card_rst_n, m_rel, "card_rst_n vs model");
        check("R8", release_pulse, m_pulse, "release_pulse vs model");
        if (release_pulse === 1'b1) rises++;
    end

    // ETU tick generator, driven at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            tick_ph++;
            etu_tick = (tick_per != 0) && (tick_ph % tick_per == 0);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int r0;
        cycles(3);
        check("R1", card_rst_n, 1'b0, "pin in reset");
        check("R1", release_pulse, 1'b0, "pulse in reset");
        rst_n = 1'b1;
        cycles(2);
        check("R1", card_rst_n, 1'b0, "pin after reset, no supply");

        // R4: zero delay, supply arrives.
        cur_req = "R4"; delay_etu = 8'd0; tick_per = 3;
        supply_ok = 1'b1; r0 = rises;
        cycles(1);
        check("R4", card_rst_n, 1'b1, "released one edge after supply");
        cycles(5);
        check("R8", logic'(rises - r0 == 1), 1'b1, "single pulse");

        // R10: released stays high despite ticks and delay changes.
        cur_req = "R10"; delay_etu = 8'd9;
        cycles(20);
        check("R10", card_rst_n, 1'b1, "stays released");

        // R2: supply loss.
        cur_req = "R2"; supply_ok = 1'b0;
        cycles(1);
        check("R2", card_rst_n, 1'b0, "low after supply loss");

        // R5: nonzero delay.
        cur_req = "R5"; delay_etu = 8'd5; tick_per = 4;
        cycles(3);
        supply_ok = 1'b1;
        cycles(10);
        check("R5", card_rst_n, 1'b0, "still counting");
        cycles(20);
        check("R5", card_rst_n, 1'b1, "released after delay");

        // R2: supply loss mid-countdown, then a full new delay.
        cur_req = "R2"; supply_ok = 1'b0; delay_etu = 8'd6;
        cycles(2);
        supply_ok = 1'b1;
        cycles(10);
        supply_ok = 1'b0;
        cycles(1);
        check("R2", card_rst_n, 1'b0, "low after mid-count loss");
        supply_ok = 1'b1;
        cycles(40);

        // R6: hold preset before power.
        cur_req = "R6"; supply_ok = 1'b0; hold_rst = 1'b1; delay_etu = 8'd3;
        cycles(2);
        supply_ok = 1'b1;
        cycles(200);
        check("R6", card_rst_n, 1'b0, "held after power-up");
        hold_rst = 1'b0;
        cycles(20);
        check("R6", card_rst_n, 1'b1, "released after hold cleared");

        // R3: hold while released.
        cur_req = "R3"; hold_rst = 1'b1;
        cycles(1);
        check("R3", card_rst_n, 1'b0, "hold pulls low");

        // R7: hold re-asserted during countdown.
        cur_req = "R7"; delay_etu = 8'd8; tick_per = 2;
        hold_rst = 1'b0;
        cycles(7);
        hold_rst = 1'b1;
        cycles(3);
        check("R7", card_rst_n, 1'b0, "abort keeps low");
        hold_rst = 1'b0;
        cycles(25);

        // R9: delay changed during countdown is ignored.
        cur_req = "R9"; hold_rst = 1'b1; delay_etu = 8'd10; tick_per = 3;
        cycles(2);
        hold_rst = 1'b0;
        cycles(4);
        delay_etu = 8'd1;
        cycles(6);
        check("R9", card_rst_n, 1'b0, "late write ignored");
        delay_etu = 8'd200;
        cycles(40);
        check("R9", card_rst_n, 1'b1, "released on latched delay");

        // R5: every-cycle ticks with delay 1.
        cur_req = "R5"; hold_rst = 1'b1; delay_etu = 8'd1; tick_per = 1;
        cycles(2);
        hold_rst = 1'b0;
        cycles(1);
        check("R5", card_rst_n, 1'b0, "start edge tick not counted");
        cycles(1);
        check("R5", card_rst_n, 1'b1, "released on first counted tick");
        cycles(3);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule